// File: doc/BRIEF.md
# Dual-Threshold Discriminator Logic with Scalers

This block is the digital back end of a sixteen-channel discriminator. Every channel supplies two asynchronous comparator levels, one from a low threshold and one from a high threshold, which gives thirty-two independent paths. Each path has three parts:

- a two-flop synchroniser with rising-edge detection;
- a one-shot that emits a fixed-width pulse, with the width set in clock cycles;
- a saturating hit counter (scaler).

The thirty-two pulses leave the block directly. They also feed a combiner. The combiner forms each of its outputs as the OR of several AND-terms, and each term is a mask over all thirty-two pulses.

A small register port sets the two pulse widths (one for all low paths, one for all high paths) and the combiner masks. Through the same port the block takes a snapshot of every scaler into a holding bank in a single cycle, clears the live scalers, and reads the held counts. Path index k is the channel number for a low-threshold path and 16 plus the channel number for a high-threshold path. The same index is used for pulse output bits, mask bits and scaler read addresses.

Top module: `disc_top`

## Requirements
- R1: A comparator level passes two synchronising flops. Only a rising edge of the synchronised level is a hit, so a level held high for many cycles gives exactly one pulse and one count.
- R2: A hit on an idle path drives that path's bit of `disc_out` high for exactly W cycles. W comes from register 0x00: bits [3:0] for the low paths and bits [7:4] for the high paths. The two widths are independent.
- R3: A width value below 2 acts as 2 and a value above 10 acts as 10.
- R4: A hit that arrives while the path's pulse is high neither restarts nor lengthens the pulse, but the scaler still counts it.
- R5: Each path's scaler increases by one for each hit. Path k is channel k at the low threshold for k < 16, and channel k-16 at the high threshold for k ≥ 16.
- R6: A scaler that has reached its all-ones value stays there on further hits.
- R7: Writing register 0x01 with bit 0 set copies all live scalers into the holding bank in the same cycle. The held count of path k reads at address 0x80+k. `cfg_rdata` shows the word for `cfg_addr` one clock later. The holding bank changes only on a copy.
- R8: Writing register 0x01 with bit 1 set zeroes all live scalers and leaves the holding bank unchanged. When both bits are set in one write, the holding bank receives the counts as they were before the clear.
- R9: Mask register 0x40 + 4·o + t is term t of combined output o, and bit k of the mask selects path k. `comb_out[o]` goes high one cycle after the cycle in which, for at least one term, every selected pulse bit is high.
- R10: A term whose mask is all zero never makes its output high.
- R11: After reset, `disc_out`, `comb_out`, all scalers, the holding bank and all masks are zero, and register 0x00 reads 0x22.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_lo | input | 16 | Asynchronous low-threshold comparator levels, one per channel |
| cmp_hi | input | 16 | Asynchronous high-threshold comparator levels, one per channel |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register address for both writes and reads |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data for the previous cycle's address |
| disc_out | output | 32 | Discriminated pulses; bits 15:0 low paths, bits 31:16 high paths |
| comb_out | output | 4 | Programmable combined outputs |

## Verification
The hardest condition to reach from the ports is scaler saturation, because a 32-bit counter cannot be filled in a run of practical length. The bench therefore places a second instance next to the main one, built with a 4-bit scaler width and driven by the same comparator and register stimulus. Twenty hits then push the narrow copy past its limit while the full-width copy still reports twenty. Retrigger suppression is reached by spacing hits four cycles apart under a ten-cycle pulse width, so that a second edge falls inside a pulse that is still active.

// File: rtl/disc_pkg.sv
package disc_pkg;
  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 32;
  localparam logic [ADDR_W-1:0] ADR_WIDTH  = 8'h00;
  localparam logic [ADDR_W-1:0] ADR_CMD    = 8'h01;
  localparam int                MASK_BASE  = 'h40;
  localparam int                HOLD_BASE  = 'h80;
  localparam int                CMD_LATCH  = 0;
  localparam int                CMD_CLEAR  = 1;
endpackage

// File: rtl/disc_path.sv
module disc_path #(
  parameter int CNT_W = 32,
  parameter int W_W   = 4,
  parameter int MIN_W = 2,
  parameter int MAX_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_in,
  input  logic [W_W-1:0]   width_cfg,
  input  logic             clr,
  output logic             pulse,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [W_W-1:0]   W_LO    = W_W'(MIN_W);
  localparam logic [W_W-1:0]   W_HI    = W_W'(MAX_W);

  logic [2:0]     sync_q;
  logic           hit;
  logic [W_W-1:0] wsel;
  logic [W_W-1:0] left_q;

  // two synchronising stages plus one history stage for edge detection
  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[1:0], cmp_in};
  end

  assign hit = sync_q[1] & ~sync_q[2];

  always_comb begin
    if (width_cfg < W_LO)      wsel = W_LO;
    else if (width_cfg > W_HI) wsel = W_HI;
    else                       wsel = width_cfg;
  end

  // non-retriggering one-shot
  always_ff @(posedge clk) begin
    if (rst) begin
      pulse  <= 1'b0;
      left_q <= '0;
    end else if (hit && !pulse) begin
      pulse  <= 1'b1;
      left_q <= wsel - W_W'(1);
    end else if (left_q != '0) begin
      left_q <= left_q - W_W'(1);
    end else begin
      pulse  <= 1'b0;
    end
  end

  // saturating scaler, clear has priority
  always_ff @(posedge clk) begin
    if (rst || clr)                    count <= '0;
    else if (hit && count != CNT_MAX)  count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/disc_combiner.sv
module disc_combiner #(
  parameter int N_SIG  = 32,
  parameter int N_OUT  = 4,
  parameter int N_TERM = 4
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [N_SIG-1:0]                   pulses,
  input  logic [N_OUT*N_TERM-1:0][N_SIG-1:0] masks,
  output logic [N_OUT-1:0]                   comb
);
  logic [N_OUT-1:0] comb_d;

  always_comb begin
    for (int o = 0; o < N_OUT; o++) begin
      comb_d[o] = 1'b0;
      for (int t = 0; t < N_TERM; t++) begin
        if (masks[o*N_TERM+t] != '0 &&
            (pulses & masks[o*N_TERM+t]) == masks[o*N_TERM+t])
          comb_d[o] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) comb <= '0;
    else     comb <= comb_d;
  end
endmodule

// File: rtl/disc_regs.sv
module disc_regs
  import disc_pkg::*;
#(
  parameter int N_SIG  = 32,
  parameter int N_OUT  = 4,
  parameter int N_TERM = 4,
  parameter int CNT_W  = 32,
  parameter int W_W    = 4
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               we,
  input  logic [ADDR_W-1:0]                  addr,
  input  logic [DATA_W-1:0]                  wdata,
  input  logic [N_SIG-1:0][CNT_W-1:0]        live,
  output logic [W_W-1:0]                     width_lo,
  output logic [W_W-1:0]                     width_hi,
  output logic [N_OUT*N_TERM-1:0][N_SIG-1:0] masks,
  output logic                               latch,
  output logic                               clr,
  output logic [DATA_W-1:0]                  rdata
);
  localparam int N_MASK = N_OUT * N_TERM;
  localparam logic [W_W-1:0] W_RST = W_W'(2);

  logic [N_SIG-1:0][CNT_W-1:0] hold_q;
  logic [DATA_W-1:0]           rd_d;
  logic                        cmd_wr;

  assign cmd_wr = we && (addr == ADR_CMD);
  assign latch  = cmd_wr && wdata[CMD_LATCH];
  assign clr    = cmd_wr && wdata[CMD_CLEAR];

  always_ff @(posedge clk) begin
    if (rst) begin
      width_lo <= W_RST;
      width_hi <= W_RST;
    end else if (we && addr == ADR_WIDTH) begin
      width_lo <= wdata[W_W-1:0];
      width_hi <= wdata[2*W_W-1:W_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      masks <= '0;
    end else begin
      for (int i = 0; i < N_MASK; i++)
        if (we && addr == ADDR_W'(MASK_BASE + i))
          masks[i] <= wdata[N_SIG-1:0];
    end
  end

  // snapshot bank: every path captured on the same edge
  always_ff @(posedge clk) begin
    if (rst)        hold_q <= '0;
    else if (latch) hold_q <= live;
  end

  always_comb begin
    rd_d = '0;
    if (addr == ADR_WIDTH) begin
      rd_d[W_W-1:0]     = width_lo;
      rd_d[2*W_W-1:W_W] = width_hi;
    end
    for (int i = 0; i < N_MASK; i++)
      if (addr == ADDR_W'(MASK_BASE + i))
        rd_d[N_SIG-1:0] = masks[i];
    for (int k = 0; k < N_SIG; k++)
      if (addr == ADDR_W'(HOLD_BASE + k))
        rd_d[CNT_W-1:0] = hold_q[k];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_d;
  end
endmodule

// File: rtl/disc_top.sv
module disc_top
  import disc_pkg::*;
#(
  parameter int N_CH   = 16,
  parameter int N_OUT  = 4,
  parameter int N_TERM = 4,
  parameter int CNT_W  = 32,
  parameter int W_W    = 4,
  parameter int MIN_W  = 2,
  parameter int MAX_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_CH-1:0]   cmp_lo,
  input  logic [N_CH-1:0]   cmp_hi,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic [2*N_CH-1:0] disc_out,
  output logic [N_OUT-1:0]  comb_out
);
  localparam int N_SIG = 2 * N_CH;

  logic [N_SIG-1:0]                   cmp_all;
  logic [N_SIG-1:0][CNT_W-1:0]        cnt_live;
  logic [W_W-1:0]                     wid_lo;
  logic [W_W-1:0]                     wid_hi;
  logic [N_OUT*N_TERM-1:0][N_SIG-1:0] mask_set;
  logic                               scl_latch;
  logic                               scl_clr;

  assign cmp_all = {cmp_hi, cmp_lo};

  for (genvar k = 0; k < N_SIG; k++) begin : g_path
    logic [W_W-1:0] wsel_k;
    if (k < N_CH) begin : g_lo
      assign wsel_k = wid_lo;
    end else begin : g_hi
      assign wsel_k = wid_hi;
    end
    disc_path #(
      .CNT_W(CNT_W), .W_W(W_W), .MIN_W(MIN_W), .MAX_W(MAX_W)
    ) u_path (
      .clk      (clk),
      .rst      (rst),
      .cmp_in   (cmp_all[k]),
      .width_cfg(wsel_k),
      .clr      (scl_clr),
      .pulse    (disc_out[k]),
      .count    (cnt_live[k])
    );
  end

  disc_combiner #(
    .N_SIG(N_SIG), .N_OUT(N_OUT), .N_TERM(N_TERM)
  ) u_comb (
    .clk   (clk),
    .rst   (rst),
    .pulses(disc_out),
    .masks (mask_set),
    .comb  (comb_out)
  );

  disc_regs #(
    .N_SIG(N_SIG), .N_OUT(N_OUT), .N_TERM(N_TERM), .CNT_W(CNT_W), .W_W(W_W)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .we      (cfg_we),
    .addr    (cfg_addr),
    .wdata   (cfg_wdata),
    .live    (cnt_live),
    .width_lo(wid_lo),
    .width_hi(wid_hi),
    .masks   (mask_set),
    .latch   (scl_latch),
    .clr     (scl_clr),
    .rdata   (cfg_rdata)
  );
endmodule

// File: rtl/disc_checker.sv
module disc_checker #(
  parameter int N_SIG = 32,
  parameter int N_OUT = 4,
  parameter int CNT_W = 32,
  parameter int MIN_W = 2,
  parameter int MAX_W = 10
) (
  input logic                        clk,
  input logic                        rst,
  input logic [N_SIG-1:0]            pulse,
  input logic [N_OUT-1:0]            comb,
  input logic                        clr,
  input logic [N_SIG-1:0][CNT_W-1:0] live
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  for (genvar k = 0; k < N_SIG; k++) begin : g_chk
    logic [7:0] run_q;
    always_ff @(posedge clk) begin
      if (rst)           run_q <= '0;
      else if (pulse[k]) run_q <= (run_q == 8'hFF) ? run_q : run_q + 8'd1;
      else               run_q <= '0;
    end

    assert_width_bounds_R2: assert property (@(posedge clk) disable iff (rst)
      $fell(pulse[k]) |-> (run_q >= 8'(MIN_W) && run_q <= 8'(MAX_W)));

    assert_no_extend_R4: assert property (@(posedge clk) disable iff (rst)
      pulse[k] |-> (run_q < 8'(MAX_W)));

    assert_count_step_R5: assert property (@(posedge clk) disable iff (rst)
      !clr |=> (live[k] == $past(live[k]) || live[k] == $past(live[k]) + CNT_W'(1)));

    assert_saturate_R6: assert property (@(posedge clk) disable iff (rst)
      (live[k] == CNT_MAX && !clr) |=> live[k] == CNT_MAX);

    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
      clr |=> live[k] == '0);
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    assert_comb_source_R9: assert property (@(posedge clk) disable iff (rst)
      comb[o] |-> $past(pulse) != '0);
  end
endmodule

bind disc_top disc_checker #(
  .N_SIG(2*N_CH), .N_OUT(N_OUT), .CNT_W(CNT_W), .MIN_W(MIN_W), .MAX_W(MAX_W)
) u_chk (
  .clk  (clk),
  .rst  (rst),
  .pulse(disc_out),
  .comb (comb_out),
  .clr  (scl_clr),
  .live (cnt_live)
);

// File: tb/tb_disc_top.sv
`timescale 1ns/1ps
module tb_disc_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cmp_lo = '0;
  logic [15:0] cmp_hi = '0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata, rdata_n;
  logic [31:0] disc_out, disc_n;
  logic [3:0]  comb_out, comb_n;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  disc_top dut (
    .clk(clk), .rst(rst), .cmp_lo(cmp_lo), .cmp_hi(cmp_hi),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .disc_out(disc_out), .comb_out(comb_out)
  );

  // narrow-scaler copy sharing all stimulus, for saturation (R6)
  disc_top #(.CNT_W(4)) dut_narrow (
    .clk(clk), .rst(rst), .cmp_lo(cmp_lo), .cmp_hi(cmp_hi),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(rdata_n), .disc_out(disc_n), .comb_out(comb_n)
  );

  // pulse monitors
  int  run_len  [32];
  int  last_run [32];
  int  rises    [32];
  logic [31:0] prev_out = '0;
  logic [3:0]  comb_seen = '0;

  always @(negedge clk) begin
    for (int k = 0; k < 32; k++) begin
      if (disc_out[k]) begin
        run_len[k]++;
        if (!prev_out[k]) rises[k]++;
      end else if (run_len[k] != 0) begin
        last_run[k] = run_len[k];
        run_len[k]  = 0;
      end
    end
    prev_out  = disc_out;
    comb_seen = comb_seen | comb_out;
  end

  task automatic clear_stats();
    for (int k = 0; k < 32; k++) begin
      run_len[k] = 0; last_run[k] = 0; rises[k] = 0;
    end
    comb_seen = '0;
  endtask

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic [31:0] dn);
    @(negedge clk);
    cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata; dn = rdata_n;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // n rising edges on low path of channel ch, high 2 / low 2 cycles
  task automatic burst_lo(input int ch, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cmp_lo[ch] = 1'b1;
      idle(2);        cmp_lo[ch] = 1'b0;
      idle(1);
    end
  endtask

  task automatic test_reset();
    logic [31:0] d, dn;
    check(disc_out == '0, "R11 disc_out after reset", disc_out, 0);
    check(comb_out == '0, "R11 comb_out after reset", comb_out, 0);
    rd(8'h00, d, dn);
    check(d == 32'h22, "R11 width register reset", d, 32'h22);
    rd(8'h80, d, dn);
    check(d == 0, "R11 holding bank reset", d, 0);
    rd(8'h47, d, dn);
    check(d == 0, "R11 mask reset", d, 0);
  endtask

  task automatic test_width();
    logic [31:0] d, dn;
    wr(8'h01, 32'h2);
    wr(8'h00, 32'h95);  // low 5, high 9
    clear_stats();
    @(negedge clk); cmp_lo[3] = 1'b1; cmp_hi[3] = 1'b1;
    idle(25);       cmp_lo[3] = 1'b0; cmp_hi[3] = 1'b0;
    idle(10);
    check(last_run[3] == 5, "R2 low pulse width", last_run[3], 5);
    check(last_run[19] == 9, "R2 high pulse width", last_run[19], 9);
    check(rises[3] == 1, "R1 held level gives one pulse", rises[3], 1);
    wr(8'h01, 32'h1);
    rd(8'h83, d, dn);
    check(d == 1, "R1 held level gives one count", d, 1);
    rd(8'h93, d, dn);
    check(d == 1, "R5 high path index 16+ch", d, 1);
  endtask

  task automatic test_clamp();
    wr(8'h00, 32'hF0);  // low 0 -> 2, high 15 -> 10
    clear_stats();
    @(negedge clk); cmp_lo[4] = 1'b1; cmp_hi[4] = 1'b1;
    idle(3);        cmp_lo[4] = 1'b0; cmp_hi[4] = 1'b0;
    idle(20);
    check(last_run[4] == 2, "R3 width floor", last_run[4], 2);
    check(last_run[20] == 10, "R3 width ceiling", last_run[20], 10);
  endtask

  task automatic test_retrigger();
    logic [31:0] d, dn;
    wr(8'h00, 32'h2A);  // low 10
    wr(8'h01, 32'h2);
    clear_stats();
    burst_lo(0, 2);
    idle(20);
    check(rises[0] == 1, "R4 no retrigger", rises[0], 1);
    check(last_run[0] == 10, "R4 no extension", last_run[0], 10);
    wr(8'h01, 32'h1);
    rd(8'h80, d, dn);
    check(d == 2, "R4 suppressed edge still counted", d, 2);
  endtask

  task automatic test_count_and_sat();
    logic [31:0] d, dn;
    wr(8'h00, 32'h22);
    wr(8'h01, 32'h2);
    clear_stats();
    burst_lo(5, 7);
    idle(10);
    check(rises[5] == 7, "R5 pulse per hit", rises[5], 7);
    wr(8'h01, 32'h1);
    rd(8'h85, d, dn);
    check(d == 7, "R5 scaler count", d, 7);
    wr(8'h01, 32'h2);
    burst_lo(1, 20);
    idle(5);
    wr(8'h01, 32'h1);
    rd(8'h81, d, dn);
    check(d == 20, "R5 wide scaler count", d, 20);
    check(dn == 15, "R6 narrow scaler saturates", dn, 15);
  endtask

  task automatic test_latch_clear();
    logic [31:0] d, dn;
    wr(8'h01, 32'h2);
    burst_lo(6, 3);
    idle(5);
    wr(8'h01, 32'h1);
    rd(8'h86, d, dn);
    check(d == 3, "R7 snapshot value", d, 3);
    burst_lo(6, 2);
    idle(5);
    rd(8'h86, d, dn);
    check(d == 3, "R7 holding stable without copy", d, 3);
    wr(8'h01, 32'h3);
    rd(8'h86, d, dn);
    check(d == 5, "R8 copy before clear in one write", d, 5);
    burst_lo(6, 4);
    idle(5);
    wr(8'h01, 32'h2);
    rd(8'h86, d, dn);
    check(d == 5, "R8 clear leaves holding", d, 5);
    wr(8'h01, 32'h1);
    rd(8'h86, d, dn);
    check(d == 0, "R8 clear zeroes live count", d, 0);
  endtask

  task automatic test_combiner();
    logic [31:0] d, dn;
    wr(8'h00, 32'h44);
    wr(8'h40, 32'h0001_0001);  // out0 term0: ch0 low AND ch0 high
    wr(8'h44, 32'h0000_0002);  // out1 term0: ch1 low
    wr(8'h45, 32'h0000_0004);  // out1 term1: ch2 low
    rd(8'h40, d, dn);
    check(d == 32'h0001_0001, "R9 mask readback", d, 32'h0001_0001);
    clear_stats();
    @(negedge clk); cmp_lo[0] = 1'b1;
    idle(3); cmp_lo[0] = 1'b0; idle(12);
    check(comb_seen[0] == 1'b0, "R9 partial AND term stays low", comb_seen[0], 0);
    clear_stats();
    @(negedge clk); cmp_lo[0] = 1'b1; cmp_hi[0] = 1'b1;
    idle(3); cmp_lo[0] = 1'b0; cmp_hi[0] = 1'b0; idle(12);
    check(comb_seen[0] == 1'b1, "R9 full AND term fires", comb_seen[0], 1);
    clear_stats();
    @(negedge clk); cmp_lo[2] = 1'b1;
    idle(3); cmp_lo[2] = 1'b0; idle(12);
    check(comb_seen[1] == 1'b1, "R9 second OR term fires", comb_seen[1], 1);
    check(comb_seen[0] == 1'b0, "R9 unrelated output stays low", comb_seen[0], 0);
    clear_stats();
    @(negedge clk); cmp_lo = '1; cmp_hi = '1;
    idle(3); cmp_lo = '0; cmp_hi = '0; idle(12);
    check(comb_seen[2] == 1'b0, "R10 zero masks never fire", comb_seen[2], 0);
    check(comb_seen[3] == 1'b0, "R10 zero masks never fire out3", comb_seen[3], 0);
  endtask

  initial begin
    clear_stats();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    idle(2);
    test_reset();
    test_width();
    test_clamp();
    test_retrigger();
    test_count_and_sat();
    test_latch_clear();
    test_combiner();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule